// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block watches a set of interrupt request lines and tells a processor when to leave its current work and which line to serve. Each line has a fixed priority chosen at elaboration. A request is remembered from its rising edge until the processor acknowledges it. A running handler can be suspended only by a request of strictly higher priority. The controller keeps a small stack of the lines now in service, so handlers can nest to any depth up to the stack size.

The processor strobes `boundary_i` when an instruction completes. A request can be offered only on such a cycle. When the controller offers a request, it raises `irq_o` and holds the line number on `vector_o` until `ack_i` arrives. On acknowledge, that line is pushed as the new running level. `eoi_i` marks the end of the running handler and pops it. When several waiting lines share the best priority, the one that became pending first is offered first. Register saving, handler code and the memory-resident stack belong to the processor.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A line becomes pending on a 0-to-1 change of its `req_i` bit. A bit that stays high after its request was acknowledged does not make the line pending again.
- R2: `irq_o` rises only in the cycle after one in which `boundary_i` was high. Without a boundary strobe, pending requests leave `irq_o` low.
- R3: When `depth_o` is 0, any pending line of any priority is offered at the next boundary strobe.
- R4: While a handler runs, a pending line whose priority is equal to or below that handler's priority is not offered.
- R5: The offered `vector_o` is the index of the pending line with the highest priority. With the default map, line i has priority (i>>1)+1, so lines 6 and 7 rank highest.
- R6: Among pending lines of equal best priority, the one whose request edge came first is offered first. Edges in the same cycle are ordered by lower index.
- R7: `ack_i` while `irq_o` is high drops `irq_o` in the next cycle, raises `depth_o` by one and clears that line's pending state. `ack_i` while `irq_o` is low has no effect.
- R8: `eoi_i` lowers `depth_o` by one and makes the level beneath the active one. `eoi_i` at depth 0 is ignored.
- R9: When `ack_i` (with `irq_o` high) and `eoi_i` fall in the same cycle at nonzero depth, `depth_o` keeps its value and the acknowledged line replaces the top level.
- R10: While `irq_o` stays high, `vector_o` does not change, even if a higher request arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_LINES | Interrupt request lines, edge-captured |
| boundary_i | input | 1 | High when the current instruction has completed |
| ack_i | input | 1 | Processor accepts the offered vector |
| eoi_i | input | 1 | Running handler has finished |
| irq_o | output | 1 | A request is offered to the processor |
| vector_o | output | $clog2(NUM_LINES) | Index of the offered line |
| depth_o | output | $clog2(STACK_DEPTH+1) | Number of nested handlers in service |

## Verification
The acknowledge of an offered line and the end of the running handler can fall in the same cycle. In that case the stack must swap its top entry in place and must not move its pointer. The directed part of the bench causes this at depth one. It then shows that a request of middle priority is still blocked, which is only true if the new, higher line took the top slot. The random part raises `ack_i` and `eoi_i` independently. This makes the collision happen often, also together with fresh request edges on the line being acknowledged. Every cycle is judged against a bench model of the stack, pending set and arrival order.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic {
    OFFER_IDLE = 1'b0,
    OFFER_HELD = 1'b1
  } offer_e;

endpackage

// File: rtl/irqc_capture.sv
// Edge capture of request lines plus a compact arrival rank per pending line.
// Pending lines always hold ranks 0..k-1; lower rank means earlier arrival.
module irqc_capture #(
  parameter int NUM_LINES = 8,
  parameter int RANK_W    = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_LINES-1:0]              req_i,
  input  logic [NUM_LINES-1:0]              clr_i,
  output logic [NUM_LINES-1:0]              pend_o,
  output logic [NUM_LINES-1:0][RANK_W-1:0]  rank_o
);

  localparam int CNT_W = $clog2(NUM_LINES + 1);

  logic [NUM_LINES-1:0]             req_q;
  logic [NUM_LINES-1:0]             pend_q;
  logic [NUM_LINES-1:0][RANK_W-1:0] rank_q;
  logic [NUM_LINES-1:0][RANK_W-1:0] rank_d;
  logic [NUM_LINES-1:0]             rise;
  logic [NUM_LINES-1:0]             arrive;
  logic [NUM_LINES-1:0]             survive;
  logic                             clr_any;
  logic [RANK_W-1:0]                clr_rank;
  logic [CNT_W-1:0]                 surv_cnt;

  assign rise    = req_i & ~req_q;
  assign arrive  = rise & (~pend_q | clr_i);
  assign survive = pend_q & ~clr_i;
  assign clr_any = |clr_i;

  always_comb begin
    clr_rank = '0;
    surv_cnt = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (clr_i[i]) clr_rank = clr_rank | rank_q[i];
      surv_cnt = surv_cnt + CNT_W'(survive[i]);
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      logic [CNT_W-1:0] ahead;
      ahead = surv_cnt;
      for (int j = 0; j < NUM_LINES; j++) begin
        if (j < i && arrive[j]) ahead = ahead + CNT_W'(1);
      end
      if (arrive[i]) begin
        rank_d[i] = RANK_W'(ahead);
      end else if (survive[i] && clr_any && (rank_q[i] > clr_rank)) begin
        rank_d[i] = rank_q[i] - RANK_W'(1);
      end else begin
        rank_d[i] = rank_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      pend_q <= '0;
      rank_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= survive | arrive;
      rank_q <= rank_d;
    end
  end

  assign pend_o = pend_q;
  assign rank_o = rank_q;

endmodule

// File: rtl/irqc_select.sv
// Picks the pending line with the highest priority, earliest rank on ties.
module irqc_select #(
  parameter int                             NUM_LINES = 8,
  parameter int                             PRIO_W    = 3,
  parameter int                             RANK_W    = 3,
  parameter int                             IDX_W     = 3,
  parameter logic [NUM_LINES*PRIO_W-1:0]    PRIO_MAP  = '0
) (
  input  logic [NUM_LINES-1:0]              pend_i,
  input  logic [NUM_LINES-1:0][RANK_W-1:0]  rank_i,
  output logic                              valid_o,
  output logic [IDX_W-1:0]                  idx_o,
  output logic [PRIO_W-1:0]                 prio_o
);

  logic [RANK_W-1:0] best_rank;

  always_comb begin
    valid_o   = 1'b0;
    idx_o     = '0;
    prio_o    = '0;
    best_rank = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      logic [PRIO_W-1:0] p;
      p = PRIO_MAP[i*PRIO_W +: PRIO_W];
      if (pend_i[i]) begin
        if (!valid_o || (p > prio_o) || ((p == prio_o) && (rank_i[i] < best_rank))) begin
          valid_o   = 1'b1;
          idx_o     = IDX_W'(i);
          prio_o    = p;
          best_rank = rank_i[i];
        end
      end
    end
  end

endmodule

// File: rtl/irqc_stack.sv
// In-service level stack. Storage has no reset so it maps to distributed RAM.
module irqc_stack #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 3,
  parameter int PTR_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] top_o,
  output logic [PTR_W-1:0]  depth_o,
  output logic              empty_o,
  output logic              full_o
);

  localparam int ADDR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr_q;
  logic [ADDR_W-1:0] top_addr;
  logic [ADDR_W-1:0] wr_addr;
  logic              do_pop;

  assign empty_o  = (ptr_q == '0);
  assign full_o   = (ptr_q == PTR_W'(DEPTH));
  assign do_pop   = pop_i && !empty_o;
  assign top_addr = ADDR_W'(ptr_q - PTR_W'(1));
  assign wr_addr  = do_pop ? top_addr : ADDR_W'(ptr_q);

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_addr] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (push_i && !do_pop) begin
      ptr_q <= ptr_q + PTR_W'(1);
    end else if (do_pop && !push_i) begin
      ptr_q <= ptr_q - PTR_W'(1);
    end
  end

  assign top_o   = mem[top_addr];
  assign depth_o = ptr_q;

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int                                NUM_LINES   = 8,
  parameter int                                PRIO_W      = 3,
  parameter logic [NUM_LINES*PRIO_W-1:0]       PRIO_MAP    = 24'o44332211,
  parameter int                                STACK_DEPTH = 8,
  localparam int                               IDX_W       = $clog2(NUM_LINES),
  localparam int                               PTR_W       = $clog2(STACK_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic                 boundary_i,
  input  logic                 ack_i,
  input  logic                 eoi_i,
  output logic                 irq_o,
  output logic [IDX_W-1:0]     vector_o,
  output logic [PTR_W-1:0]     depth_o
);

  import irqc_pkg::*;

  localparam int RANK_W = IDX_W;

  offer_e                            offer_q;
  logic [IDX_W-1:0]                  vec_q;
  logic [NUM_LINES-1:0]              pend;
  logic [NUM_LINES-1:0][RANK_W-1:0]  rank;
  logic [NUM_LINES-1:0]              clr;
  logic                              sel_valid;
  logic [IDX_W-1:0]                  sel_idx;
  logic [PRIO_W-1:0]                 sel_prio;
  logic [IDX_W-1:0]                  top_idx;
  logic [PRIO_W-1:0]                 top_prio;
  logic                              stk_empty;
  logic                              stk_full;
  logic                              eligible;
  logic                              take;

  irqc_capture #(
    .NUM_LINES (NUM_LINES),
    .RANK_W    (RANK_W)
  ) i_capture (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend),
    .rank_o (rank)
  );

  irqc_select #(
    .NUM_LINES (NUM_LINES),
    .PRIO_W    (PRIO_W),
    .RANK_W    (RANK_W),
    .IDX_W     (IDX_W),
    .PRIO_MAP  (PRIO_MAP)
  ) i_select (
    .pend_i  (pend),
    .rank_i  (rank),
    .valid_o (sel_valid),
    .idx_o   (sel_idx),
    .prio_o  (sel_prio)
  );

  irqc_stack #(
    .DEPTH  (STACK_DEPTH),
    .DATA_W (IDX_W),
    .PTR_W  (PTR_W)
  ) i_stack (
    .clk     (clk),
    .rst     (rst),
    .push_i  (take),
    .pop_i   (eoi_i),
    .data_i  (vec_q),
    .top_o   (top_idx),
    .depth_o (depth_o),
    .empty_o (stk_empty),
    .full_o  (stk_full)
  );

  assign top_prio = PRIO_MAP[top_idx*PRIO_W +: PRIO_W];
  assign eligible = sel_valid && !stk_full && (stk_empty || (sel_prio > top_prio));
  assign take     = (offer_q == OFFER_HELD) && ack_i;

  always_comb begin
    clr = '0;
    if (take) clr[vec_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      offer_q <= OFFER_IDLE;
      vec_q   <= '0;
    end else begin
      case (offer_q)
        OFFER_IDLE: begin
          if (boundary_i && eligible) begin
            offer_q <= OFFER_HELD;
            vec_q   <= sel_idx;
          end
        end
        OFFER_HELD: begin
          if (ack_i) offer_q <= OFFER_IDLE;
        end
        default: offer_q <= OFFER_IDLE;
      endcase
    end
  end

  assign irq_o    = (offer_q == OFFER_HELD);
  assign vector_o = vec_q;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_LINES   = 8,
  parameter int STACK_DEPTH = 8,
  localparam int IDX_W      = $clog2(NUM_LINES),
  localparam int PTR_W      = $clog2(STACK_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             boundary_i,
  input logic             ack_i,
  input logic             eoi_i,
  input logic             irq_o,
  input logic [IDX_W-1:0] vector_o,
  input logic [PTR_W-1:0] depth_o
);

  AST_OFFER_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(boundary_i)); // R2

  AST_VECTOR_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq_o && $past(irq_o)) |-> $stable(vector_o)); // R10

  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ack_i) |=> !irq_o); // R7

  AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ack_i && !eoi_i) |=> (depth_o == $past(depth_o) + PTR_W'(1))); // R7

  AST_EOI_POPS: assert property (@(posedge clk) disable iff (rst)
    (!(irq_o && ack_i) && eoi_i && depth_o != '0) |=> (depth_o == $past(depth_o) - PTR_W'(1))); // R8

  AST_EOI_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!(irq_o && ack_i) && eoi_i && depth_o == '0) |=> (depth_o == '0)); // R8

  AST_SWAP_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ack_i && eoi_i && depth_o != '0) |=> $stable(depth_o)); // R9

endmodule

bind nest_irq_ctrl irqc_checker #(
  .NUM_LINES   (NUM_LINES),
  .STACK_DEPTH (STACK_DEPTH)
) i_irqc_checker (
  .clk        (clk),
  .rst        (rst),
  .boundary_i (boundary_i),
  .ack_i      (ack_i),
  .eoi_i      (eoi_i),
  .irq_o      (irq_o),
  .vector_o   (vector_o),
  .depth_o    (depth_o)
);

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req = '0;
  logic       bnd = 1'b0;
  logic       ack = 1'b0;
  logic       eoi = 1'b0;
  logic       irq;
  logic [2:0] vec;
  logic [3:0] depth;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  bit         m_pend  [8];
  int         m_stamp [8];
  int         m_stk   [8];
  int         m_seq   = 0;
  logic [7:0] m_prev  = '0;
  bit         m_irq   = 1'b0;
  int         m_vec   = 0;
  int         m_depth = 0;

  always #2 clk = ~clk;

  nest_irq_ctrl i_nest_irq_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req),
    .boundary_i (bnd),
    .ack_i      (ack),
    .eoi_i      (eoi),
    .irq_o      (irq),
    .vector_o   (vec),
    .depth_o    (depth)
  );

  function automatic int prio_of(int i);
    return (i >> 1) + 1;
  endfunction

  function automatic int pick();
    int best = -1;
    for (int i = 0; i < 8; i++) begin
      if (m_pend[i]) begin
        if (best < 0 || prio_of(i) > prio_of(best) ||
            (prio_of(i) == prio_of(best) && m_stamp[i] < m_stamp[best]))
          best = i;
      end
    end
    return best;
  endfunction

  task automatic model_step();
    int  best = pick();
    int  top  = (m_depth > 0) ? m_stk[m_depth-1] : 0;
    bit  elig = (best >= 0) && (m_depth < 8) &&
                (m_depth == 0 || prio_of(best) > prio_of(top));
    bit  take = m_irq && ack;
    bit  pop  = eoi && (m_depth > 0);
    int  tv   = m_vec;
    if (!m_irq && bnd && elig) begin
      m_irq = 1'b1;
      m_vec = best;
    end else if (take) begin
      m_irq = 1'b0;
    end
    if (take && pop) m_stk[m_depth-1] = tv;
    else if (take) begin m_stk[m_depth] = tv; m_depth++; end
    else if (pop) m_depth--;
    if (take) m_pend[tv] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (req[i] && !m_prev[i] && !m_pend[i]) begin
        m_pend[i]  = 1'b1;
        m_stamp[i] = m_seq;
        m_seq++;
      end
    end
    m_prev = req;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample at following negedge, compare with model
  task automatic cyc(logic [7:0] r, bit b, bit a, bit e, string tag);
    req = r; bnd = b; ack = a; eoi = e;
    @(posedge clk);
    @(negedge clk);
    model_step();
    chk(irq == m_irq, {tag, " irq"}, int'(irq), int'(m_irq));
    chk(int'(vec) == m_vec, {tag, " vector"}, int'(vec), m_vec);
    chk(int'(depth) == m_depth, {tag, " depth"}, int'(depth), m_depth);
  endtask

  // explicit hand-worked expectations; ev < 0 skips the vector
  task automatic expect3(string tag, bit ei, int ev, int ed);
    chk(irq == ei, {tag, " irq hand"}, int'(irq), int'(ei));
    if (ev >= 0) chk(int'(vec) == ev, {tag, " vector hand"}, int'(vec), ev);
    chk(int'(depth) == ed, {tag, " depth hand"}, int'(depth), ed);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect3("R7 reset", 1'b0, 0, 0);

    r = 8'h24;                                   // lines 2 and 5
    cyc(r, 0, 0, 0, "R1");  expect3("R1", 0, -1, 0);
    cyc(r, 0, 0, 0, "R2");  expect3("R2 no strobe", 0, -1, 0);
    cyc(r, 1, 0, 0, "R5");  expect3("R5 best of 2,5", 1, 5, 0);
    cyc(r, 0, 1, 0, "R7");  expect3("R7 ack", 0, 5, 1);
    cyc(r, 1, 0, 0, "R4");  expect3("R4 lower blocked", 0, -1, 1);
    r = 8'h34;
    cyc(r, 0, 0, 0, "R1");
    cyc(r, 1, 0, 0, "R4");  expect3("R4 equal blocked", 0, -1, 1);
    r = 8'hB4;
    cyc(r, 0, 0, 0, "R1");
    cyc(r, 1, 0, 0, "R5");  expect3("R5 preempt by 7", 1, 7, 1);
    cyc(r, 0, 1, 0, "R7");  expect3("R7 nest", 0, 7, 2);
    cyc(r, 0, 0, 1, "R8");  expect3("R8 pop", 0, -1, 1);
    cyc(r, 1, 0, 0, "R4");  expect3("R4 after pop", 0, -1, 1);
    cyc(r, 0, 0, 1, "R8");  expect3("R8 last pop", 0, -1, 0);
    cyc(r, 1, 0, 0, "R3");  expect3("R3 idle takes any", 1, 4, 0);
    cyc(r, 0, 1, 1, "R8");  expect3("R8 eoi empty ignored", 0, -1, 1);
    cyc(r, 0, 1, 0, "R7");  expect3("R7 stray ack", 0, -1, 1);

    r = 8'hBC;                                   // line 3 after line 2
    cyc(r, 0, 0, 0, "R6");
    cyc(r, 0, 0, 1, "R8");  expect3("R8", 0, -1, 0);
    cyc(r, 1, 0, 0, "R6");  expect3("R6 earlier 2 over 3", 1, 2, 0);
    cyc(r, 0, 1, 0, "R7");  expect3("R7", 0, -1, 1);
    r = 8'hFC;
    cyc(r, 0, 0, 0, "R1");
    cyc(r, 1, 0, 0, "R5");  expect3("R5 line 6", 1, 6, 1);
    cyc(r, 0, 1, 1, "R9");  expect3("R9 swap depth", 0, -1, 1);
    r = 8'hEC;
    cyc(r, 0, 0, 0, "R1");
    r = 8'hFC;
    cyc(r, 0, 0, 0, "R1");
    cyc(r, 1, 0, 0, "R9");  expect3("R9 top is 6", 0, -1, 1);
    cyc(r, 0, 0, 1, "R8");  expect3("R8", 0, -1, 0);
    cyc(r, 1, 0, 0, "R5");  expect3("R5 line 4 over 3", 1, 4, 0);
    cyc(r, 0, 1, 0, "R7");
    cyc(r, 0, 0, 1, "R8");
    cyc(r, 1, 0, 0, "R6");  expect3("R6 line 3", 1, 3, 0);
    cyc(r, 0, 1, 0, "R7");
    cyc(r, 0, 0, 1, "R8");

    r = 8'hFF;                                   // lines 0,1 same cycle
    cyc(r, 0, 0, 0, "R6");
    cyc(r, 1, 0, 0, "R6");  expect3("R6 same cycle low index", 1, 0, 0);
    cyc(r, 0, 1, 0, "R7");
    cyc(r, 0, 0, 1, "R8");
    cyc(r, 1, 0, 0, "R6");  expect3("R6 then line 1", 1, 1, 0);
    cyc(r, 0, 1, 0, "R7");
    cyc(r, 0, 0, 1, "R8");
    cyc(r, 1, 0, 0, "R1");  expect3("R1 held level no repend", 0, -1, 0);

    r = 8'hFB;
    cyc(r, 0, 0, 0, "R10");
    r = 8'hFF;
    cyc(r, 0, 0, 0, "R10");
    cyc(r, 1, 0, 0, "R10"); expect3("R10 offer 2", 1, 2, 0);
    r = 8'h7F;
    cyc(r, 0, 0, 0, "R10");
    r = 8'hFF;
    cyc(r, 0, 0, 0, "R10");
    cyc(r, 1, 0, 0, "R10"); expect3("R10 vector held", 1, 2, 0);
    cyc(r, 0, 1, 0, "R7");
    cyc(r, 1, 0, 0, "R5");  expect3("R5 7 preempts 2", 1, 7, 1);
    cyc(r, 0, 1, 0, "R7");  expect3("R7", 0, -1, 2);
    cyc(r, 0, 0, 1, "R8");
    cyc(r, 0, 0, 1, "R8");  expect3("R8 back to program", 0, -1, 0);

    for (int k = 0; k < 4000; k++) begin
      logic [7:0] r2;
      bit b, a, e;
      r2 = req;
      if ($urandom % 4 == 0) r2[$urandom % 8] = ~r2[$urandom % 8];
      b = ($urandom % 2) == 0;
      a = irq ? (($urandom % 2) == 0) : (($urandom % 16) == 0);
      e = ($urandom % 6) == 0;
      cyc(r2, b, a, e, "R6 random");
    end

    done = 1'b1;
    finish_run();
  end

endmodule